// File: doc/BRIEF.md
# Byte-Lane Register Access Adapter

This adapter connects a host port that addresses single bytes, little-endian, across a 128-byte window to three register targets that only take aligned 32-bit words. The three targets are a 16-word core register file, an 8-word DMA register block and a single bus-control register. Each host request is a byte offset, a length of 1, 2 or 4 bytes and, for writes, right-aligned data.

A narrow write is turned into a read-merge-write. The adapter reads the target's current word, replaces only the addressed bytes and issues one aligned full-word write strobe one cycle later. A read fetches the aligned word, shifts the addressed bytes down to bit 0 and zeroes everything above the requested length.

Offsets that map to no target, illegal lengths and byte ranges that cross a word boundary are all rejected. A rejected read returns zero, a rejected write produces no strobe, and both raise a one-cycle error flag.

A write to a target lands one cycle after its request. For that reason, a request in the next cycle that touches the same word takes its current value from the pending write rather than from the target.

Top module: `lane_bridge`

## Requirements
- R1: Offsets 0x00 to 0x3F select the core register file with word index equal to offset shifted right by 2; a valid write pulses only `core_we`.
- R2: Offsets 0x40 to 0x5F select the DMA block with index equal to (offset - 0x40) shifted right by 2; a valid write pulses only `dma_we`.
- R3: Offsets 0x70 to 0x73 select the single bus-control register (index 0); a valid write pulses only `ctl_we`; at most one write strobe is high in any cycle.
- R4: Offsets 0x60 to 0x6F and 0x74 to 0x7F are invalid: a read returns zero, a write raises no strobe and leaves every target unchanged, and `rsp_err` is set.
- R5: Lengths 1, 2 and 4 are legal; any other `req_len` value is invalid. Write data bits above 8*len are ignored.
- R6: A legal write issues exactly one aligned word write whose bytes offset mod 4 up to offset mod 4 + len - 1 carry the new data (byte k of `req_wdata` into byte offset mod 4 + k) and whose other bytes keep the target's current value.
- R7: A legal read returns the target word shifted right by 8*(offset mod 4), with bits at and above 8*len forced to zero.
- R8: An access with (offset mod 4) + len greater than 4 is invalid, handled as in R4.
- R9: `rsp_ready` is high exactly in the cycle after each request cycle, including back-to-back requests. `rsp_err` and `rsp_rdata` are valid only in that cycle, and `rsp_err` is low in a cycle that follows no invalid request.
- R10: A request in the cycle right after a write to the same word sees the written word, for both reads and merges.
- R11: After reset, `rsp_ready`, `rsp_err`, all write strobes and `rsp_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (7) | Byte offset in the window |
| req_len | input | 3 | Access length in bytes (1, 2 or 4) |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_ready | output | 1 | Response cycle, one cycle after request |
| rsp_err | output | 1 | Request was invalid |
| rsp_rdata | output | 32 | Read data, right-aligned and masked |
| rd_idx | output | IDX_W (4) | Word index of the current request, for target reads |
| core_rdata | input | 32 | Core register file word at `rd_idx` |
| dma_rdata | input | 32 | DMA block word at `rd_idx` |
| ctl_rdata | input | 32 | Bus-control register value |
| core_we | output | 1 | Write strobe to core register file |
| dma_we | output | 1 | Write strobe to DMA block |
| ctl_we | output | 1 | Write strobe to bus-control register |
| wr_idx | output | IDX_W (4) | Word index of the issued write |
| wr_data | output | 32 | Full merged word of the issued write |

## Verification
The hardest case to reach is a request that touches a word whose write is still in flight. The target has not yet absorbed the earlier word, so only the forwarding path gives the right merge or read value. The bench drives three requests to one core word on consecutive cycles: a full-word write, a single-byte write into the middle of that word, then a full-word read. A stale merge would then show up in both the second strobe's data and the read result. Word-crossing and illegal lengths sit inside mapped regions, and the bench reads the word back afterwards to show that nothing was written.

// File: rtl/lane_bridge_pkg.sv
package lane_bridge_pkg;

  localparam int WORD_BYTES = 4;
  localparam int WORD_BITS  = 8 * WORD_BYTES;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_CORE = 2'd1,
    RGN_DMA  = 2'd2,
    RGN_CTL  = 2'd3
  } region_e;

  // Only 1, 2 and 4 byte accesses are accepted.
  function automatic logic len_is_legal(input logic [2:0] len);
    return (len == 3'd1) || (len == 3'd2) || (len == 3'd4);
  endfunction

  // True when the addressed byte range stays within one aligned word.
  function automatic logic stays_in_word(input logic [1:0] off, input logic [2:0] len);
    return ({2'b00, off} + {1'b0, len}) <= 4'd4;
  endfunction

endpackage

// File: rtl/lane_bridge_rst_sync.sv
module lane_bridge_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;

endmodule

// File: rtl/lane_bridge_decode.sv
module lane_bridge_decode
  import lane_bridge_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int CORE_WORDS = 16,
  parameter int DMA_BASE   = 'h40,
  parameter int DMA_WORDS  = 8,
  parameter int CTL_BASE   = 'h70,
  parameter int IDX_W      = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        len,
  output region_e           region,
  output logic [IDX_W-1:0]  idx,
  output logic [1:0]        off,
  output logic              legal
);

  localparam int CORE_END = CORE_WORDS * WORD_BYTES;
  localparam int DMA_END  = DMA_BASE + DMA_WORDS * WORD_BYTES;
  localparam int CTL_WORD = CTL_BASE / WORD_BYTES;

  int unsigned a;

  always_comb begin
    a      = int'(addr);
    region = RGN_NONE;
    idx    = '0;
    if (a < CORE_END) begin
      region = RGN_CORE;
      idx    = IDX_W'(a / WORD_BYTES);
    end else if ((a >= DMA_BASE) && (a < DMA_END)) begin
      region = RGN_DMA;
      idx    = IDX_W'((a - DMA_BASE) / WORD_BYTES);
    end else if ((a / WORD_BYTES) == CTL_WORD) begin
      region = RGN_CTL;
      idx    = '0;
    end
  end

  assign off   = addr[1:0];
  assign legal = (region != RGN_NONE) && len_is_legal(len) && stays_in_word(off, len);

endmodule

// File: rtl/lane_bridge_lanes.sv
module lane_bridge_lanes
  import lane_bridge_pkg::*;
(
  input  logic [WORD_BITS-1:0] cur_word,
  input  logic [WORD_BITS-1:0] wdata,
  input  logic [1:0]           off,
  input  logic [2:0]           len,
  output logic [WORD_BITS-1:0] merged,
  output logic [WORD_BITS-1:0] rd_view
);

  logic [WORD_BITS-1:0]  shifted_in;
  logic [WORD_BITS-1:0]  shifted_out;
  logic [WORD_BYTES-1:0] lane_en;
  logic [WORD_BYTES-1:0] keep_en;

  assign shifted_in  = wdata << {off, 3'b000};
  assign shifted_out = cur_word >> {off, 3'b000};

  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
    // lane b is written when off <= b < off + len
    assign lane_en[b] = (b >= int'(off)) && (b < (int'(off) + int'(len)));
    // read byte b survives when b < len
    assign keep_en[b] = (b < int'(len));
    assign merged[8*b +: 8]  = lane_en[b] ? shifted_in[8*b +: 8] : cur_word[8*b +: 8];
    assign rd_view[8*b +: 8] = keep_en[b] ? shifted_out[8*b +: 8] : 8'h00;
  end

endmodule

// File: rtl/lane_bridge.sv
module lane_bridge
  import lane_bridge_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int CORE_WORDS = 16,
  parameter int DMA_BASE   = 'h40,
  parameter int DMA_WORDS  = 8,
  parameter int CTL_BASE   = 'h70,
  parameter int IDX_W      = $clog2(CORE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_len,
  input  logic [31:0]       req_wdata,
  output logic              rsp_ready,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [31:0]       core_rdata,
  input  logic [31:0]       dma_rdata,
  input  logic [31:0]       ctl_rdata,
  output logic              core_we,
  output logic              dma_we,
  output logic              ctl_we,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [31:0]       wr_data
);

  logic rst_s;

  lane_bridge_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s)
  );

  region_e            dec_region;
  logic [IDX_W-1:0]   dec_idx;
  logic [1:0]         dec_off;
  logic               dec_legal;

  lane_bridge_decode #(
    .ADDR_W     (ADDR_W),
    .CORE_WORDS (CORE_WORDS),
    .DMA_BASE   (DMA_BASE),
    .DMA_WORDS  (DMA_WORDS),
    .CTL_BASE   (CTL_BASE),
    .IDX_W      (IDX_W)
  ) u_dec (
    .addr   (req_addr),
    .len    (req_len),
    .region (dec_region),
    .idx    (dec_idx),
    .off    (dec_off),
    .legal  (dec_legal)
  );

  // pending-write registers
  logic             wr_pend_q;
  region_e          wr_region_q;
  logic [IDX_W-1:0] wr_idx_q;
  logic [31:0]      wr_data_q;
  // response registers
  logic             ready_q;
  logic             err_q;
  logic [31:0]      rdata_q;

  logic [31:0] tgt_word;
  logic        fwd_hit;
  logic [31:0] cur_word;
  logic [31:0] merged_word;
  logic [31:0] read_view;

  always_comb begin
    unique case (dec_region)
      RGN_CORE: tgt_word = core_rdata;
      RGN_DMA:  tgt_word = dma_rdata;
      RGN_CTL:  tgt_word = ctl_rdata;
      default:  tgt_word = '0;
    endcase
  end

  // a write issued last cycle has not reached its target yet
  assign fwd_hit  = wr_pend_q && (wr_region_q == dec_region) && (wr_idx_q == dec_idx);
  assign cur_word = fwd_hit ? wr_data_q : tgt_word;

  lane_bridge_lanes u_lanes (
    .cur_word (cur_word),
    .wdata    (req_wdata),
    .off      (dec_off),
    .len      (req_len),
    .merged   (merged_word),
    .rd_view  (read_view)
  );

  // next-state
  logic        wr_go;
  logic        err_d;
  logic [31:0] rdata_d;

  always_comb begin
    wr_go   = req_valid && req_write && dec_legal;
    err_d   = req_valid && !dec_legal;
    rdata_d = (req_valid && !req_write && dec_legal) ? read_view : '0;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      wr_pend_q <= 1'b0;
      ready_q   <= 1'b0;
      err_q     <= 1'b0;
      rdata_q   <= '0;
    end else begin
      wr_pend_q <= wr_go;
      ready_q   <= req_valid;
      err_q     <= err_d;
      rdata_q   <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      wr_region_q <= RGN_NONE;
      wr_idx_q    <= '0;
      wr_data_q   <= '0;
    end else if (wr_go) begin
      wr_region_q <= dec_region;
      wr_idx_q    <= dec_idx;
      wr_data_q   <= merged_word;
    end
  end

  assign rd_idx    = dec_idx;
  assign rsp_ready = ready_q;
  assign rsp_err   = err_q;
  assign rsp_rdata = rdata_q;
  assign core_we   = wr_pend_q && (wr_region_q == RGN_CORE);
  assign dma_we    = wr_pend_q && (wr_region_q == RGN_DMA);
  assign ctl_we    = wr_pend_q && (wr_region_q == RGN_CTL);
  assign wr_idx    = wr_idx_q;
  assign wr_data   = wr_data_q;

  // ---------------- assertions ----------------
  a_r9_ready_follows_req: assert property (@(posedge clk) disable iff (!rst_s)
    req_valid |=> rsp_ready);

  a_r9_no_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_s)
    !req_valid |=> !rsp_ready);

  a_r4_err_blocks_write: assert property (@(posedge clk) disable iff (!rst_s)
    rsp_err |-> !(core_we || dma_we || ctl_we));

  a_r4_err_data_zero: assert property (@(posedge clk) disable iff (!rst_s)
    rsp_err |-> (rsp_rdata == 32'h0));

  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0({core_we, dma_we, ctl_we}));

  a_r6_strobe_needs_write: assert property (@(posedge clk) disable iff (!rst_s)
    (core_we || dma_we || ctl_we) |-> $past(req_valid && req_write));

  a_r7_byte_read_masked: assert property (@(posedge clk) disable iff (!rst_s)
    (req_valid && !req_write && (req_len == 3'd1)) |=> (rsp_rdata[31:8] == 24'h0));

  a_r8_cross_is_error: assert property (@(posedge clk) disable iff (!rst_s)
    (req_valid && (({2'b00, req_addr[1:0]} + {1'b0, req_len}) > 4'd4)) |=> rsp_err);

endmodule

// File: tb/lane_bridge_tb.sv
module lane_bridge_tb;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [6:0]  req_addr;
  logic [2:0]  req_len;
  logic [31:0] req_wdata;
  logic        rsp_ready;
  logic        rsp_err;
  logic [31:0] rsp_rdata;
  logic [3:0]  rd_idx;
  logic [31:0] core_rdata;
  logic [31:0] dma_rdata;
  logic [31:0] ctl_rdata;
  logic        core_we;
  logic        dma_we;
  logic        ctl_we;
  logic [3:0]  wr_idx;
  logic [31:0] wr_data;

  int n_tests;
  int n_fail;
  logic done;

  lane_bridge u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_len    (req_len),
    .req_wdata  (req_wdata),
    .rsp_ready  (rsp_ready),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata),
    .rd_idx     (rd_idx),
    .core_rdata (core_rdata),
    .dma_rdata  (dma_rdata),
    .ctl_rdata  (ctl_rdata),
    .core_we    (core_we),
    .dma_we     (dma_we),
    .ctl_we     (ctl_we),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data)
  );

  // 125 MHz
  initial clk = 1'b0;
  always #4 clk = ~clk;

  // simple target banks
  logic [31:0] core_mem [16];
  logic [31:0] dma_mem  [8];
  logic [31:0] ctl_reg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) core_mem[i] <= '0;
      for (int i = 0; i < 8; i++)  dma_mem[i]  <= '0;
      ctl_reg <= '0;
    end else begin
      if (core_we) core_mem[wr_idx]     <= wr_data;
      if (dma_we)  dma_mem[wr_idx[2:0]] <= wr_data;
      if (ctl_we)  ctl_reg              <= wr_data;
    end
  end

  assign core_rdata = core_mem[rd_idx];
  assign dma_rdata  = dma_mem[rd_idx[2:0]];
  assign ctl_rdata  = ctl_reg;

  // captured response
  logic        cap_ready;
  logic        cap_err;
  logic [31:0] cap_rdata;
  logic [2:0]  cap_we;
  logic [3:0]  cap_idx;
  logic [31:0] cap_wdata;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic capture();
    cap_ready = rsp_ready;
    cap_err   = rsp_err;
    cap_rdata = rsp_rdata;
    cap_we    = {core_we, dma_we, ctl_we};
    cap_idx   = wr_idx;
    cap_wdata = wr_data;
  endtask

  task automatic drive(input logic w, input logic [6:0] a, input logic [2:0] l, input logic [31:0] d);
    req_valid = 1'b1;
    req_write = w;
    req_addr  = a;
    req_len   = l;
    req_wdata = d;
  endtask

  task automatic issue(input logic w, input logic [6:0] a, input logic [2:0] l, input logic [31:0] d);
    @(negedge clk);
    drive(w, a, l, d);
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
    capture();
  endtask

  task automatic t_reset();
    capture();
    chk("R11 ready", 32'(cap_ready), 32'h0);
    chk("R11 err", 32'(cap_err), 32'h0);
    chk("R11 rdata", cap_rdata, 32'h0);
    chk("R11 strobes", 32'(cap_we), 32'h0);
  endtask

  task automatic t_core();
    issue(1'b1, 7'h08, 3'd4, 32'hDEADBEEF);
    chk("R1 strobe", 32'(cap_we), 32'h4);
    chk("R1 index", 32'(cap_idx), 32'h2);
    chk("R1 data", cap_wdata, 32'hDEADBEEF);
    chk("R1 ready", 32'(cap_ready), 32'h1);
    issue(1'b0, 7'h08, 3'd4, 32'h0);
    chk("R1 readback", cap_rdata, 32'hDEADBEEF);
  endtask

  task automatic t_dma();
    issue(1'b1, 7'h4C, 3'd4, 32'hCAFEF00D);
    chk("R2 strobe", 32'(cap_we), 32'h2);
    chk("R2 index", 32'(cap_idx), 32'h3);
    issue(1'b0, 7'h4C, 3'd4, 32'h0);
    chk("R2 readback", cap_rdata, 32'hCAFEF00D);
    issue(1'b0, 7'h0C, 3'd4, 32'h0);
    chk("R2 core untouched", cap_rdata, 32'h0);
  endtask

  task automatic t_ctl();
    issue(1'b1, 7'h70, 3'd4, 32'h01000000);
    chk("R3 strobe", 32'(cap_we), 32'h1);
    chk("R3 index", 32'(cap_idx), 32'h0);
    issue(1'b0, 7'h73, 3'd1, 32'h0);
    chk("R3 top byte", cap_rdata, 32'h01);
    issue(1'b0, 7'h70, 3'd2, 32'h0);
    chk("R3 low half", cap_rdata, 32'h0);
  endtask

  task automatic t_partial();
    issue(1'b1, 7'h0A, 3'd2, 32'hFFFF1234);
    chk("R6 half merge", cap_wdata, 32'h1234BEEF);
    chk("R6 strobe", 32'(cap_we), 32'h4);
    issue(1'b1, 7'h0B, 3'd1, 32'h00000077);
    chk("R6 byte merge", cap_wdata, 32'h7734BEEF);
    issue(1'b1, 7'h08, 3'd2, 32'hABCD5678);
    chk("R5 upper data ignored", cap_wdata, 32'h77345678);
    chk("R6 index", 32'(cap_idx), 32'h2);
  endtask

  task automatic t_reads();
    issue(1'b0, 7'h09, 3'd1, 32'h0);
    chk("R7 byte1", cap_rdata, 32'h56);
    issue(1'b0, 7'h0A, 3'd2, 32'h0);
    chk("R7 half2", cap_rdata, 32'h7734);
    issue(1'b0, 7'h09, 3'd2, 32'h0);
    chk("R7 half1", cap_rdata, 32'h3456);
    issue(1'b0, 7'h0B, 3'd1, 32'h0);
    chk("R7 byte3", cap_rdata, 32'h77);
  endtask

  task automatic t_invalid();
    issue(1'b0, 7'h60, 3'd4, 32'h0);
    chk("R4 read err", 32'(cap_err), 32'h1);
    chk("R4 read zero", cap_rdata, 32'h0);
    issue(1'b1, 7'h64, 3'd4, 32'hFFFFFFFF);
    chk("R4 write dropped", 32'(cap_we), 32'h0);
    chk("R4 write err", 32'(cap_err), 32'h1);
    issue(1'b1, 7'h7C, 3'd1, 32'hFF);
    chk("R4 high write dropped", 32'(cap_we), 32'h0);
    issue(1'b0, 7'h74, 3'd4, 32'h0);
    chk("R4 read 0x74 err", 32'(cap_err), 32'h1);
    @(negedge clk);
    capture();
    chk("R9 err single cycle", 32'(cap_err), 32'h0);
    chk("R9 ready idle", 32'(cap_ready), 32'h0);
    issue(1'b0, 7'h70, 3'd4, 32'h0);
    chk("R4 ctl unchanged", cap_rdata, 32'h01000000);
    chk("R4 valid no err", 32'(cap_err), 32'h0);
  endtask

  task automatic t_cross();
    issue(1'b1, 7'h0B, 3'd2, 32'hFFFF);
    chk("R8 cross write dropped", 32'(cap_we), 32'h0);
    chk("R8 cross write err", 32'(cap_err), 32'h1);
    issue(1'b0, 7'h0A, 3'd4, 32'h0);
    chk("R8 cross read err", 32'(cap_err), 32'h1);
    chk("R8 cross read zero", cap_rdata, 32'h0);
    issue(1'b1, 7'h08, 3'd3, 32'hFFFFFF);
    chk("R5 len3 err", 32'(cap_err), 32'h1);
    chk("R5 len3 dropped", 32'(cap_we), 32'h0);
    issue(1'b0, 7'h08, 3'd4, 32'h0);
    chk("R8 word unchanged", cap_rdata, 32'h77345678);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    drive(1'b1, 7'h14, 3'd4, 32'h11223344);
    @(negedge clk);
    capture();
    chk("R9 ready b2b first", 32'(cap_ready), 32'h1);
    drive(1'b1, 7'h15, 3'd1, 32'h000000AA);
    @(negedge clk);
    capture();
    chk("R10 forwarded merge", cap_wdata, 32'h1122AA44);
    chk("R9 ready b2b second", 32'(cap_ready), 32'h1);
    drive(1'b0, 7'h14, 3'd4, 32'h0);
    @(negedge clk);
    req_valid = 1'b0;
    capture();
    chk("R10 forwarded read", cap_rdata, 32'h1122AA44);
    chk("R9 ready b2b third", 32'(cap_ready), 32'h1);
    @(negedge clk);
    capture();
    chk("R9 ready drops", 32'(cap_ready), 32'h0);
    issue(1'b0, 7'h14, 3'd4, 32'h0);
    chk("R10 landed", cap_rdata, 32'h1122AA44);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    n_tests   = 0;
    n_fail    = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    req_len   = 3'd4;
    req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_core();
    t_dma();
    t_ctl();
    t_partial();
    t_reads();
    t_invalid();
    t_cross();
    t_back_to_back();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule